// File: doc/BRIEF.md
# Locked-Region Mail Exchange

This block coordinates a producing engine and a consuming engine that share one exchange memory. When the producer finishes a data block, it posts a mail that carries the block's start address and its length. The hub queues the mail toward the consumer and records the named address range in a small lock table. While the range is locked, any producer write that lands inside it is reported as a violation and the write is held back.

The consumer sees a level interrupt while mail is waiting. It asks for a mail and gets one only when one is queued, so a receive request also serves as a synchronisation point. The consumer copies the block into its own local store and then sends back a release that names the block's base address. The release unlocks the range at once, even though the data has not been processed yet. It also queues a return mail so the producer knows the space is free again.

A release that names a base with no active lock is rejected. It sets a sticky error flag and leaves every other piece of state as it was.

Top module: `mbox_lock_hub`

## Requirements
- R1: An accepted post (post_valid and post_ready high at a clock edge) shows its address and size at rcv_addr/rcv_size after that edge, once every earlier mail has been taken.
- R2: After a post of base B and size S is accepted, a write check at address A with B <= A < B+S raises wchk_viol and drops wr_allow. Addresses outside every locked range give wr_allow high and wchk_viol low. Both outputs are combinational on wchk_valid/wchk_addr.
- R3: fwd_irq is high exactly while the forward queue holds at least one mail.
- R4: rcv_grant rises only when rcv_req is high and a mail is queued. A request on an empty queue grants nothing and changes no state.
- R5: post_ready is low while all LOCKS (default 4) lock slots are in use, or while the forward queue holds DEPTH (default 4) mails.
- R6: An accepted release whose rel_addr equals the base of a locked range frees that range from the next cycle on. It also queues a return mail carrying that base, and rtn_irq stays high while return mail waits. rtn_grant/rtn_addr pop it the same way as R4.
- R7: A release whose address matches no locked base sets err_flag. It unlocks nothing and queues no return mail.
- R8: Mails in each direction are delivered in the order they were accepted, and each one is delivered exactly once.
- R9: rel_ready is low while the return queue holds DEPTH mails.
- R10: err_flag, once set, stays high until reset. Reset clears every lock, both queues and err_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Producer offers a finished block |
| post_addr | input | ADDR_W | Block start address |
| post_size | input | ADDR_W | Block length in words |
| post_ready | output | 1 | Post can be accepted this cycle |
| fwd_irq | output | 1 | Forward mail waiting for the consumer |
| rcv_req | input | 1 | Consumer asks for the next mail |
| rcv_grant | output | 1 | Head mail is taken at this edge |
| rcv_addr | output | ADDR_W | Head mail start address |
| rcv_size | output | ADDR_W | Head mail length |
| rel_valid | input | 1 | Consumer releases a copied block |
| rel_addr | input | ADDR_W | Base address of the released block |
| rel_ready | output | 1 | Release can be accepted this cycle |
| rtn_irq | output | 1 | Return mail waiting for the producer |
| rtn_req | input | 1 | Producer asks for the next return mail |
| rtn_grant | output | 1 | Return head is taken at this edge |
| rtn_addr | output | ADDR_W | Freed base address in the return head |
| wchk_valid | input | 1 | Producer write logic queries an address |
| wchk_addr | input | ADDR_W | Address to be written |
| wchk_viol | output | 1 | Queried address lies in a locked range |
| wr_allow | output | 1 | Queried write may go ahead |
| err_flag | output | 1 | Sticky flag for an unmatched release |

## Verification
There are two timing classes of result. Write-check results and the grant strobes are combinational. Queue contents, lock changes, the interrupts and err_flag are registered, so they change one edge after the accepting edge.

The bench drives every input just after a falling edge. It reads the combinational outputs 1 ns later, in the same half-cycle. It reads the registered effects only after the next falling edge, which falls after the single rising edge that updates them.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // True when addr lies in the half-open span [base, base+len).
  function automatic logic in_span(logic [31:0] addr, logic [31:0] base,
                                   logic [31:0] len);
    return (addr >= base) && ((addr - base) < len);
  endfunction

  // Next pointer value for a circular buffer of the given depth.
  function automatic logic [31:0] wrap_inc(logic [31:0] ptr, logic [31:0] depth);
    return (ptr == depth - 1) ? 32'd0 : ptr + 32'd1;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  import mbox_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rd_data = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) begin
        mem_q[wp_q] <= wr_data;
        wp_q        <= PW'(wrap_inc(32'(wp_q), 32'(DEPTH)));
      end
      if (rd_en) rp_q <= PW'(wrap_inc(32'(rp_q), 32'(DEPTH)));
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  p_count_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |=> !empty);

endmodule

// File: rtl/mbox_lock_table.sv
module mbox_lock_table #(
  parameter int ADDR_W = 16,
  parameter int LOCKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_base,
  input  logic [ADDR_W-1:0] alloc_len,
  input  logic              rel_req,
  input  logic [ADDR_W-1:0] rel_base,
  output logic              rel_hit,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_hit,
  output logic              full
);
  import mbox_pkg::*;

  localparam int IW = (LOCKS > 1) ? $clog2(LOCKS) : 1;

  logic [LOCKS-1:0]  vld_q;
  logic [ADDR_W-1:0] base_q [LOCKS];
  logic [ADDR_W-1:0] len_q  [LOCKS];

  logic [IW-1:0]    free_idx, rel_idx;
  logic [LOCKS-1:0] span_hit;

  assign full = &vld_q;

  // Lowest free slot wins the allocation.
  always_comb begin
    free_idx = '0;
    for (int i = LOCKS - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IW'(i);
  end

  // Lowest slot whose base matches the release wins.
  always_comb begin
    rel_idx = '0;
    rel_hit = 1'b0;
    for (int i = LOCKS - 1; i >= 0; i--)
      if (vld_q[i] && base_q[i] == rel_base) begin
        rel_idx = IW'(i);
        rel_hit = 1'b1;
      end
  end

  generate
    for (genvar g = 0; g < LOCKS; g++) begin : g_span
      assign span_hit[g] = vld_q[g] &&
        in_span(32'(chk_addr), 32'(base_q[g]), 32'(len_q[g]));
    end
  endgenerate

  assign chk_hit = |span_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (rel_req && rel_hit) vld_q[rel_idx] <= 1'b0;
      if (alloc && !full) begin
        vld_q[free_idx]  <= 1'b1;
        base_q[free_idx] <= alloc_base;
        len_q[free_idx]  <= alloc_len;
      end
    end
  end

  p_lock_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !(rel_req && rel_hit)) |=>
      ($countones(vld_q) == $past($countones(vld_q)) + 1));
  p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && rel_hit && !alloc) |=>
      ($countones(vld_q) + 1 == $past($countones(vld_q))));
  p_alloc_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);

endmodule

// File: rtl/mbox_lock_hub.sv
module mbox_lock_hub #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  parameter int LOCKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic [ADDR_W-1:0] post_addr,
  input  logic [ADDR_W-1:0] post_size,
  output logic              post_ready,
  output logic              fwd_irq,
  input  logic              rcv_req,
  output logic              rcv_grant,
  output logic [ADDR_W-1:0] rcv_addr,
  output logic [ADDR_W-1:0] rcv_size,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_addr,
  output logic              rel_ready,
  output logic              rtn_irq,
  input  logic              rtn_req,
  output logic              rtn_grant,
  output logic [ADDR_W-1:0] rtn_addr,
  input  logic              wchk_valid,
  input  logic [ADDR_W-1:0] wchk_addr,
  output logic              wchk_viol,
  output logic              wr_allow,
  output logic              err_flag
);

  localparam int MW = 2 * ADDR_W;

  // Named internal events for the assertions.
  logic fwd_empty, fwd_full, rtn_empty, rtn_full, tbl_full;
  logic post_fire, rel_fire, rel_hit, rel_good, rel_bad, chk_hit;
  logic [MW-1:0] fwd_head;
  logic          err_q;

  assign post_ready = !fwd_full && !tbl_full;
  assign post_fire  = post_valid && post_ready;
  assign rel_ready  = !rtn_full;
  assign rel_fire   = rel_valid && rel_ready;
  assign rel_good   = rel_fire && rel_hit;
  assign rel_bad    = rel_fire && !rel_hit;
  assign rcv_grant  = rcv_req && !fwd_empty;
  assign rtn_grant  = rtn_req && !rtn_empty;
  assign fwd_irq    = !fwd_empty;
  assign rtn_irq    = !rtn_empty;
  assign {rcv_addr, rcv_size} = fwd_head;
  assign wchk_viol  = wchk_valid && chk_hit;
  assign wr_allow   = wchk_valid && !chk_hit;
  assign err_flag   = err_q;

  mbox_fifo #(.W(MW), .DEPTH(DEPTH)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .wr_en(post_fire), .wr_data({post_addr, post_size}),
    .rd_en(rcv_grant), .rd_data(fwd_head),
    .empty(fwd_empty), .full(fwd_full)
  );

  mbox_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_rtn (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rel_good), .wr_data(rel_addr),
    .rd_en(rtn_grant), .rd_data(rtn_addr),
    .empty(rtn_empty), .full(rtn_full)
  );

  mbox_lock_table #(.ADDR_W(ADDR_W), .LOCKS(LOCKS)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .alloc(post_fire), .alloc_base(post_addr), .alloc_len(post_size),
    .rel_req(rel_fire), .rel_base(rel_addr), .rel_hit(rel_hit),
    .chk_addr(wchk_addr), .chk_hit(chk_hit), .full(tbl_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (rel_bad) err_q <= 1'b1;
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_bad_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_bad |=> err_flag);
  p_bad_no_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_bad && rtn_empty && !rtn_req) |=> !rtn_irq);
  p_post_mail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    post_fire |=> fwd_irq);
  p_release_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_good |=> rtn_irq);
  p_refuse_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_full || fwd_full) |-> !post_ready);
  p_check_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wchk_viol && wr_allow));

endmodule

// File: tb/mbox_lock_hub_bench.sv
`timescale 1ns/1ps
module mbox_lock_hub_bench;

  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic post_valid = 1'b0, rcv_req = 1'b0, rel_valid = 1'b0;
  logic rtn_req = 1'b0, wchk_valid = 1'b0;
  logic [AW-1:0] post_addr = '0, post_size = '0, rel_addr = '0, wchk_addr = '0;
  logic post_ready, fwd_irq, rcv_grant, rel_ready, rtn_irq, rtn_grant;
  logic wchk_viol, wr_allow, err_flag;
  logic [AW-1:0] rcv_addr, rcv_size, rtn_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mbox_lock_hub u_mbox_lock_hub (
    .clk(clk), .rst_n(rst_n),
    .post_valid(post_valid), .post_addr(post_addr), .post_size(post_size),
    .post_ready(post_ready), .fwd_irq(fwd_irq),
    .rcv_req(rcv_req), .rcv_grant(rcv_grant), .rcv_addr(rcv_addr), .rcv_size(rcv_size),
    .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_ready(rel_ready),
    .rtn_irq(rtn_irq), .rtn_req(rtn_req), .rtn_grant(rtn_grant), .rtn_addr(rtn_addr),
    .wchk_valid(wchk_valid), .wchk_addr(wchk_addr), .wchk_viol(wchk_viol),
    .wr_allow(wr_allow), .err_flag(err_flag)
  );

  // Write-check vectors with blocks A=0x100/0x40, B=0x200/0x10, C=0x300/1 locked:
  // {expected violation, address}
  localparam logic [AW:0] CHK_TBL [12] = '{
    {1'b0, 16'h00FF}, {1'b1, 16'h0100}, {1'b1, 16'h0120}, {1'b1, 16'h013F},
    {1'b0, 16'h0140}, {1'b0, 16'h01FF}, {1'b1, 16'h0200}, {1'b1, 16'h020F},
    {1'b0, 16'h0210}, {1'b1, 16'h0300}, {1'b0, 16'h0301}, {1'b0, 16'hFFFF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic post(logic [AW-1:0] a, logic [AW-1:0] s);
    @(negedge clk);
    post_valid = 1'b1; post_addr = a; post_size = s;
    #1 check("R5 post accepted", 32'(post_ready), 1);
    @(negedge clk);
    post_valid = 1'b0;
  endtask

  task automatic release_blk(logic [AW-1:0] a);
    @(negedge clk);
    rel_valid = 1'b1; rel_addr = a;
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic take_mail(logic [AW-1:0] a, logic [AW-1:0] s);
    @(negedge clk);
    rcv_req = 1'b1;
    #1;
    check("R4 grant with mail", 32'(rcv_grant), 1);
    check("R8 order addr", 32'(rcv_addr), 32'(a));
    check("R1 size", 32'(rcv_size), 32'(s));
    @(negedge clk);
    rcv_req = 1'b0;
  endtask

  task automatic take_return(logic [AW-1:0] a);
    @(negedge clk);
    rtn_req = 1'b1;
    #1;
    check("R6 return grant", 32'(rtn_grant), 1);
    check("R6 return base", 32'(rtn_addr), 32'(a));
    @(negedge clk);
    rtn_req = 1'b0;
  endtask

  task automatic wcheck(logic [AW-1:0] a, logic exp_viol, string req);
    @(negedge clk);
    wchk_valid = 1'b1; wchk_addr = a;
    #1;
    check(req, 32'(wchk_viol), 32'(exp_viol));
    check(req, 32'(wr_allow), 32'(!exp_viol));
    wchk_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset post_ready", 32'(post_ready), 1);
    check("R10 reset fwd_irq", 32'(fwd_irq), 0);
    check("R10 reset rtn_irq", 32'(rtn_irq), 0);
    check("R10 reset err", 32'(err_flag), 0);
    wcheck(16'h0100, 1'b0, "R2 nothing locked after reset");

    post(16'h0100, 16'h0040);
    check("R3 irq after post", 32'(fwd_irq), 1);
    post(16'h0200, 16'h0010);
    post(16'h0300, 16'h0001);

    for (int i = 0; i < 12; i++)
      wcheck(CHK_TBL[i][AW-1:0], CHK_TBL[i][AW], "R2 vector");

    take_mail(16'h0100, 16'h0040);
    take_mail(16'h0200, 16'h0010);
    take_mail(16'h0300, 16'h0001);
    check("R3 irq low when empty", 32'(fwd_irq), 0);

    @(negedge clk);
    rcv_req = 1'b1;
    #1 check("R4 no grant on empty", 32'(rcv_grant), 0);
    @(negedge clk);
    rcv_req = 1'b0;
    check("R4 empty request no state", 32'(fwd_irq), 0);

    release_blk(16'h0120);
    check("R7 err set", 32'(err_flag), 1);
    check("R7 no return mail", 32'(rtn_irq), 0);
    wcheck(16'h0120, 1'b1, "R7 lock kept");

    release_blk(16'h0100);
    wcheck(16'h0100, 1'b0, "R6 unlocked");
    wcheck(16'h0200, 1'b1, "R6 other lock kept");
    check("R6 rtn_irq", 32'(rtn_irq), 1);
    take_return(16'h0100);
    check("R6 rtn_irq cleared", 32'(rtn_irq), 0);

    post(16'h0400, 16'h0008);
    post(16'h0500, 16'h0008);
    @(negedge clk);
    check("R5 table full refuses", 32'(post_ready), 0);
    wcheck(16'h0504, 1'b1, "R2 fourth slot");

    release_blk(16'h0200);
    release_blk(16'h0300);
    release_blk(16'h0400);
    release_blk(16'h0500);
    @(negedge clk);
    check("R9 return queue full", 32'(rel_ready), 0);
    check("R5 table free again", 32'(post_ready), 1);

    post(16'h0600, 16'h0002);
    post(16'h0700, 16'h0003);
    @(negedge clk);
    check("R5 forward queue full refuses", 32'(post_ready), 0);

    take_mail(16'h0400, 16'h0008);
    take_mail(16'h0500, 16'h0008);
    take_mail(16'h0600, 16'h0002);
    take_mail(16'h0700, 16'h0003);
    take_return(16'h0200);
    take_return(16'h0300);
    take_return(16'h0400);
    take_return(16'h0500);
    check("R8 return drained once", 32'(rtn_irq), 0);
    check("R10 err still set", 32'(err_flag), 1);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 err cleared by reset", 32'(err_flag), 0);
    wcheck(16'h0600, 1'b0, "R10 locks cleared by reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule